// File: doc/BRIEF.md
# Score-Dependent Reaction Delay Timer

This block times the pause between arming a reaction round and lighting the go indicator in a two-player reaction game. A wide base counter runs while the delay is enabled and emits a tick each time it wraps. A bank of small step counters, one per game position, counts those ticks. Only the counter whose position matches the current tie flag and score codes advances. When that counter reaches its multiplier, the end-of-delay flag rises.

The wait therefore equals a position-specific multiplier times the base period. The pause changes as the game moves between the tie position and a one- or two-point lead for either player. The surrounding game controller raises the enable to start the wait and pulses the clear to rearm it. The clear acts asynchronously and also serves as the block's reset.

Top module: `reactDelayTimer`

## Requirements
- R1: While `cntClr` is high, every counter is held at zero and `delayDone` is low. After `cntClr` falls, `delayDone` stays low until the selected delay has elapsed.
- R2: The base counter advances only on enabled clock edges and produces one tick every 2^`BASE_W` enabled cycles. Every delay is therefore a whole multiple of that period.
- R3: Position select uses these score codes: 2'b01 means a lead of one point and 2'b10 means a lead of two points. `tieFlag` has the highest priority, then the `p2Score` code, then the `p1Score` code. At most one step counter advances on any tick.
- R4: After the clear is released, `delayDone` first goes high after exactly M × 2^`BASE_W` enabled cycles. M is 8 for tie, 2 for player 2 ahead by one, 7 for player 2 ahead by two, 6 for player 1 ahead by one, and 3 for player 1 ahead by two.
- R5: Once high, `delayDone` stays high until `cntClr` is pulsed, even if further ticks occur or the score inputs change.
- R6: While `delayEn` is low, no counter advances and `delayDone` keeps its value. Enabled cycles from before and after a pause add together.
- R7: When `tieFlag` is low and neither score code is 2'b01 or 2'b10, no step counter advances and `delayDone` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| cntClr | input | 1 | Asynchronous clear of all counters, active high |
| delayEn | input | 1 | Delay count enable |
| tieFlag | input | 1 | Game is in the tie position |
| p1Score | input | 2 | Player 1 lead code |
| p2Score | input | 2 | Player 2 lead code |
| delayDone | output | 1 | End-of-delay flag, held until cleared |

## Verification
The hardest case to reach from the ports is a delay that is paused part-way. The bench has to show that base progress and step progress both survive an interval with the enable low. It drops `delayEn` a few cycles before the first tick and holds it low for longer than a full base period. It then resumes and checks that the flag rises exactly when the enabled cycles add up to the expected total. The other hard case is a tick arriving while no position is valid. Score code 2'b11 and the all-zero non-tie input are held for well past the longest delay to cover it.

// File: rtl/rdtPkg.sv
package rdtPkg;

  localparam int NUM_PATHS = 5;

  // Index of each game position in the step-counter bank.
  localparam int PATH_TIE  = 0;
  localparam int PATH_P2L1 = 1;
  localparam int PATH_P2L2 = 2;
  localparam int PATH_P1L1 = 3;
  localparam int PATH_P1L2 = 4;

  // Score codes driven by the game controller.
  localparam logic [1:0] LEAD_ONE = 2'b01;
  localparam logic [1:0] LEAD_TWO = 2'b10;

  typedef struct packed {
    logic                 tick;
    logic [NUM_PATHS-1:0] advance;
  } rdtStrobes_t;

  function automatic int maxOfFive(input int a, input int b, input int c,
                                   input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/rdtBaseCounter.sv
module rdtBaseCounter #(
  parameter int BASE_W = 25
) (
  input  logic              clk,
  input  logic              cntClr,
  input  logic              delayEn,
  output logic [BASE_W-1:0] baseCount,
  output logic              baseWrap
);

  localparam logic [BASE_W-1:0] BASE_MAX = '1;

  always_ff @(posedge clk or posedge cntClr) begin
    if (cntClr) begin
      baseCount <= '0;
    end else if (delayEn) begin
      baseCount <= baseCount + 1'b1;
    end
  end

  assign baseWrap = (baseCount == BASE_MAX);

endmodule

// File: rtl/rdtPathCtrl.sv
module rdtPathCtrl
  import rdtPkg::*;
(
  input  logic        delayEn,
  input  logic        baseWrap,
  input  logic        tieFlag,
  input  logic [1:0]  p1Score,
  input  logic [1:0]  p2Score,
  output rdtStrobes_t strobes
);

  logic [NUM_PATHS-1:0] pathSel;

  always_comb begin
    pathSel = '0;
    if (tieFlag) begin
      pathSel[PATH_TIE] = 1'b1;
    end else if (p2Score == LEAD_ONE) begin
      pathSel[PATH_P2L1] = 1'b1;
    end else if (p2Score == LEAD_TWO) begin
      pathSel[PATH_P2L2] = 1'b1;
    end else if (p1Score == LEAD_ONE) begin
      pathSel[PATH_P1L1] = 1'b1;
    end else if (p1Score == LEAD_TWO) begin
      pathSel[PATH_P1L2] = 1'b1;
    end
  end

  always_comb begin
    strobes.tick    = delayEn & baseWrap;
    strobes.advance = pathSel & {NUM_PATHS{strobes.tick}};
  end

endmodule

// File: rtl/rdtStepBank.sv
module rdtStepBank
  import rdtPkg::*;
#(
  parameter int                           CNT_W    = 4,
  parameter logic [NUM_PATHS*CNT_W-1:0]   MULT_VEC = '0
) (
  input  logic        clk,
  input  logic        cntClr,
  input  rdtStrobes_t strobes,
  output logic        delayDone
);

  logic [NUM_PATHS-1:0] pathTerm;

  for (genvar i = 0; i < NUM_PATHS; i++) begin : g_step
    localparam logic [CNT_W-1:0] LIMIT = MULT_VEC[i*CNT_W +: CNT_W];
    logic [CNT_W-1:0] stepCount;

    always_ff @(posedge clk or posedge cntClr) begin
      if (cntClr) begin
        stepCount <= '0;
      end else if (strobes.advance[i] && (stepCount != LIMIT)) begin
        stepCount <= stepCount + 1'b1;
      end
    end

    assign pathTerm[i] = (stepCount == LIMIT);
  end

  assign delayDone = |pathTerm;

endmodule

// File: rtl/reactDelayTimer.sv
module reactDelayTimer
  import rdtPkg::*;
#(
  parameter int BASE_W    = 25,
  parameter int MULT_TIE  = 8,
  parameter int MULT_P2L1 = 2,
  parameter int MULT_P2L2 = 7,
  parameter int MULT_P1L1 = 6,
  parameter int MULT_P1L2 = 3
) (
  input  logic       clk,
  input  logic       cntClr,
  input  logic       delayEn,
  input  logic       tieFlag,
  input  logic [1:0] p1Score,
  input  logic [1:0] p2Score,
  output logic       delayDone
);

  localparam int MULT_MAX = maxOfFive(MULT_TIE, MULT_P2L1, MULT_P2L2,
                                      MULT_P1L1, MULT_P1L2);
  localparam int CNT_W = $clog2(MULT_MAX + 1);
  localparam logic [NUM_PATHS*CNT_W-1:0] MULT_VEC = {
    CNT_W'(MULT_P1L2), CNT_W'(MULT_P1L1), CNT_W'(MULT_P2L2),
    CNT_W'(MULT_P2L1), CNT_W'(MULT_TIE)
  };

  logic [BASE_W-1:0] baseCount;
  logic              baseWrap;
  rdtStrobes_t       strobes;

  rdtBaseCounter #(.BASE_W(BASE_W)) uBase (
    .clk       (clk),
    .cntClr    (cntClr),
    .delayEn   (delayEn),
    .baseCount (baseCount),
    .baseWrap  (baseWrap)
  );

  rdtPathCtrl uCtrl (
    .delayEn  (delayEn),
    .baseWrap (baseWrap),
    .tieFlag  (tieFlag),
    .p1Score  (p1Score),
    .p2Score  (p2Score),
    .strobes  (strobes)
  );

  rdtStepBank #(.CNT_W(CNT_W), .MULT_VEC(MULT_VEC)) uBank (
    .clk       (clk),
    .cntClr    (cntClr),
    .strobes   (strobes),
    .delayDone (delayDone)
  );

endmodule

// File: rtl/rdtChecker.sv
module rdtChecker
  import rdtPkg::*;
(
  input logic                 clk,
  input logic                 cntClr,
  input logic                 delayEn,
  input logic                 tieFlag,
  input logic [1:0]           p1Score,
  input logic [1:0]           p2Score,
  input logic                 baseWrap,
  input logic [NUM_PATHS-1:0] advance,
  input logic                 delayDone
);

  logic noPosition;
  assign noPosition = !tieFlag &&
                      (p1Score != LEAD_ONE) && (p1Score != LEAD_TWO) &&
                      (p2Score != LEAD_ONE) && (p2Score != LEAD_TWO);

  always @(posedge clk) begin
    if (cntClr) begin
      p_clear_low_r1: assert (!delayDone);
    end
  end

  p_tick_gated_r2: assert property (@(posedge clk) disable iff (cntClr)
    (|advance) |-> (baseWrap && delayEn));

  p_single_path_r3: assert property (@(posedge clk) disable iff (cntClr)
    $onehot0(advance));

  p_rise_on_tick_r4: assert property (@(posedge clk) disable iff (cntClr)
    $rose(delayDone) |-> $past(|advance));

  p_sticky_r5: assert property (@(posedge clk) disable iff (cntClr)
    delayDone |=> delayDone);

  p_freeze_r6: assert property (@(posedge clk) disable iff (cntClr)
    !delayEn |=> $stable(delayDone));

  p_no_position_r7: assert property (@(posedge clk) disable iff (cntClr)
    noPosition |-> (advance == '0));

endmodule

bind reactDelayTimer rdtChecker uChk (
  .clk       (clk),
  .cntClr    (cntClr),
  .delayEn   (delayEn),
  .tieFlag   (tieFlag),
  .p1Score   (p1Score),
  .p2Score   (p2Score),
  .baseWrap  (baseWrap),
  .advance   (strobes.advance),
  .delayDone (delayDone)
);

// File: tb/reactDelayTimer_test.sv
module reactDelayTimer_test;

  localparam int BW     = 3;
  localparam int PERIOD = 1 << BW;
  localparam int LIMIT  = 10 * PERIOD;
  localparam int NVEC   = 9;

  // Fields: [8] tie, [7:6] p1Score, [5:4] p2Score, [3:0] multiplier (0 = never)
  localparam logic [8:0] VECS [NVEC] = '{
    {1'b1, 2'b00, 2'b00, 4'd8},
    {1'b1, 2'b01, 2'b10, 4'd8},
    {1'b0, 2'b00, 2'b01, 4'd2},
    {1'b0, 2'b00, 2'b10, 4'd7},
    {1'b0, 2'b01, 2'b00, 4'd6},
    {1'b0, 2'b10, 2'b00, 4'd3},
    {1'b0, 2'b10, 2'b01, 4'd2},
    {1'b0, 2'b00, 2'b00, 4'd0},
    {1'b0, 2'b11, 2'b11, 4'd0}
  };

  logic       clk = 1'b0;
  logic       cntClr = 1'b1;
  logic       delayEn = 1'b0;
  logic       tieFlag = 1'b0;
  logic [1:0] p1Score = 2'b00;
  logic [1:0] p2Score = 2'b00;
  logic       delayDone;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  reactDelayTimer #(.BASE_W(BW)) uut (
    .clk       (clk),
    .cntClr    (cntClr),
    .delayEn   (delayEn),
    .tieFlag   (tieFlag),
    .p1Score   (p1Score),
    .p2Score   (p2Score),
    .delayDone (delayDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rearm(input logic t, input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    delayEn = 1'b0;
    cntClr  = 1'b1;
    tieFlag = t;
    p1Score = a;
    p2Score = b;
    @(negedge clk);
    cntClr  = 1'b0;
    delayEn = 1'b1;
  endtask

  // Counts enabled cycles until delayDone, -1 if it never rises within LIMIT.
  task automatic measure(output int got);
    got = -1;
    for (int k = 1; k <= LIMIT; k++) begin
      @(negedge clk);
      if (delayDone && got < 0) got = k;
    end
  endtask

  initial begin
    int got;
    int exp;
    int cnt;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(delayDone == 1'b0, "R1 done low in clear", delayDone, 0);

    // Table walk: R2 R3 R4 R7
    for (int v = 0; v < NVEC; v++) begin
      rearm(VECS[v][8], VECS[v][7:6], VECS[v][5:4]);
      measure(got);
      exp = (VECS[v][3:0] == 0) ? -1 : int'(VECS[v][3:0]) * PERIOD;
      check(got == exp, (VECS[v][3:0] == 0) ? "R7 no position" : "R2/R3/R4 delay",
            got, exp);
    end

    // R5: sticky while ticks continue and scores change
    rearm(1'b0, 2'b00, 2'b01);
    repeat (2 * PERIOD) @(negedge clk);
    check(delayDone == 1'b1, "R4 p2 lead one", delayDone, 1);
    tieFlag = 1'b1;
    repeat (3 * PERIOD) @(negedge clk);
    check(delayDone == 1'b1, "R5 held after score change", delayDone, 1);

    // R6: freeze keeps a high flag
    delayEn = 1'b0;
    repeat (5) @(negedge clk);
    check(delayDone == 1'b1, "R6 held with enable low", delayDone, 1);

    // R1: clear drops the flag
    cntClr = 1'b1;
    #1;
    check(delayDone == 1'b0, "R1 async clear", delayDone, 0);
    @(negedge clk);
    cntClr = 1'b0;
    delayEn = 1'b1;
    tieFlag = 1'b0;
    p1Score = 2'b10;
    p2Score = 2'b00;
    @(negedge clk);
    check(delayDone == 1'b0, "R1 low after release", delayDone, 0);

    // R6: pause mid-delay (p1 lead two, 3 periods = 24 enabled cycles)
    rearm(1'b0, 2'b10, 2'b00);
    repeat (PERIOD - 2) @(negedge clk);
    delayEn = 1'b0;
    repeat (3 * PERIOD) @(negedge clk);
    check(delayDone == 1'b0, "R6 no progress paused", delayDone, 0);
    delayEn = 1'b1;
    cnt = PERIOD - 2;
    got = -1;
    for (int k = 0; k < LIMIT; k++) begin
      @(negedge clk);
      cnt++;
      if (delayDone && got < 0) got = cnt;
    end
    check(got == 3 * PERIOD, "R6 resumed total", got, 3 * PERIOD);

    // R2: one cycle short of the shortest delay
    rearm(1'b0, 2'b00, 2'b01);
    repeat (2 * PERIOD - 1) @(negedge clk);
    check(delayDone == 1'b0, "R2 one cycle early", delayDone, 0);
    @(negedge clk);
    check(delayDone == 1'b1, "R2 on period boundary", delayDone, 1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule